// File: doc/BRIEF.md
# Programmable Bit-Serial LFSR Scrambler

This block whitens a serial bit stream with a linear-feedback shift register whose feedback taps and starting value are both loaded at run time. A 24-bit tap mask selects which register stages feed the parity, so any feedback polynomial of degree 24 or less can be used. A 24-bit seed gives the starting value. One bit is accepted on each clock where the bit-valid strobe is high. Its scrambled version leaves the block one clock later, together with a delayed copy of the strobe.

Two modes are available.
- **Frame-synchronous mode:** the register runs freely. It is reloaded with the seed at the bit that carries the frame-start flag, so a descrambler that is given the same seed and mask can follow it.
- **Self-synchronizing mode:** each scrambled output bit is shifted back into the register. A descrambler that uses the same mask locks on by itself after 24 bits and needs no seed.

Scrambling takes place only while the effective enable is high. The effective enable comes either from a hardware strobe or from a software enable bit, chosen by a select input. This lets preamble bits pass through unchanged while user data is scrambled.

Internally, a small two-state controller records whether the bit held in the output stage was scrambled.
- **ST_PASS** (the reset state): the held bit is sent unchanged.
- **ST_SCR**: the held bit is XORed with the keystream bit captured with it.
- **Transitions:**
  - A valid bit with the effective enable high moves the controller to ST_SCR (transition SCR_BIT).
  - A valid bit with the enable low moves it to ST_PASS (transition PASS_BIT).
  - With no valid bit, the controller stays in its current state (transition IDLE_HOLD).

For each valid bit the controller also issues one register action:
- hold;
- load the seed;
- step from the current state;
- step from the seed;
- self-synchronizing step.

Top module: `lfsr_scrambler`

## Requirements
- R1: At reset the following values apply:
  - `out_vld` and `bit_out` are 0.
  - The tap mask is 24'h006000 (x^15 + x^14 + 1).
  - The seed is 24'h007FFF.
  - The register holds the seed value.

  Mask bit i taps register bit i. Register bit 0 holds the most recently inserted bit, so bit i is the value inserted i+1 bits ago.
- R2: `out_vld` equals `bit_vld` delayed by one clock. The result for a bit accepted at a clock edge is on `bit_out` right after that edge.
- R3: In frame-synchronous mode (`self_mode`=0) with the enable high, the keystream bit k is the XOR of (c AND mask), where c is the seed if `frame_start` is set and the register otherwise. The output is `bit_in` XOR k, and the register becomes {c[22:0], k}.
- R4: In self-synchronizing mode (`self_mode`=1) with the enable high, k is the XOR of (register AND mask). The output o is `bit_in` XOR k, and the register becomes {register[22:0], o}. `frame_start` has no effect in this mode.
- R5: With the enable low, `bit_out` equals `bit_in` and the register holds its value. The one exception is frame-synchronous mode with `frame_start` set: there the register is loaded with the seed.
- R6: When `en_sel_sw`=1 the effective enable is `sw_en` and `hw_en` is ignored. When `en_sel_sw`=0 the effective enable is `hw_en` and `sw_en` is ignored.
- R7: A clock with `cfg_wr`=1 loads `cfg_mask` and `cfg_seed`. The new values apply from the next clock on. A bit accepted in the same clock as the write still uses the old values.
- R8: On a clock with `bit_vld`=0, the register and `bit_out` keep their values.
- R9: In self-synchronizing mode, a descrambler that uses the same mask and any starting state recovers the input bits from the 25th scrambled bit onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the tap mask and the seed |
| cfg_mask | input | 24 | New tap mask |
| cfg_seed | input | 24 | New seed |
| self_mode | input | 1 | 1 = self-synchronizing, 0 = frame-synchronous |
| en_sel_sw | input | 1 | Enable source select: 1 = software bit, 0 = hardware strobe |
| sw_en | input | 1 | Software enable bit |
| hw_en | input | 1 | Hardware enable strobe |
| frame_start | input | 1 | Marks the first bit of a frame |
| bit_vld | input | 1 | Input bit valid |
| bit_in | input | 1 | Serial input bit |
| bit_out | output | 1 | Serial output bit, one clock later |
| out_vld | output | 1 | Output bit valid |

## Verification
The bench builds the block with its default parameters: a 24-bit register, a reset polynomial of x^15 + x^14 + 1, and a 15-ones seed. This brings the reset-default keystream within reach of a direct comparison. A run-time write of a degree-23 polynomial then shows that the full mask and seed width is used, with taps in the upper bits that the reset polynomial never touches. The bench covers the following:
- preamble passing through with the enable low;
- gaps in the valid strobe;
- the enable source being swapped;
- a self-synchronizing run with stray frame-start flags;
- a bench-side descrambler that starts from a zero state and must lock by the 25th bit.

// File: rtl/lfsr_scr_pkg.sv
package lfsr_scr_pkg;

    // Controller state: was the bit held in the output stage scrambled
    typedef enum logic {
        ST_PASS = 1'b0,
        ST_SCR  = 1'b1
    } scr_state_e;

    // Register action for the current clock
    typedef enum logic [2:0] {
        ACT_IDLE       = 3'd0,
        ACT_HOLD       = 3'd1,
        ACT_LOAD       = 3'd2,
        ACT_STEP_FRAME = 3'd3,
        ACT_STEP_SEED  = 3'd4,
        ACT_STEP_SELF  = 3'd5
    } scr_act_e;

endpackage

// File: rtl/lfsr_scr_cfg.sv
module lfsr_scr_cfg #(
    parameter int unsigned W = 24,
    parameter logic [W-1:0] RST_MASK = '0,
    parameter logic [W-1:0] RST_SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_mask,
    input  logic [W-1:0] cfg_seed,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] seed_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= RST_MASK;
            seed_q <= RST_SEED;
        end else if (cfg_wr) begin
            mask_q <= cfg_mask;
            seed_q <= cfg_seed;
        end
    end

endmodule

// File: rtl/lfsr_scr_core.sv
module lfsr_scr_core
    import lfsr_scr_pkg::*;
#(
    parameter int unsigned W = 24,
    parameter logic [W-1:0] RST_SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  scr_act_e     act,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] seed,
    input  logic         data_in,
    output logic         key,
    output logic [W-1:0] state_q
);

    logic [W-1:0] cur;
    logic [W-1:0] tap_prod;
    logic [W-1:0] state_d;

    // A step from the seed starts the frame from the programmed value
    assign cur = (act == ACT_STEP_SEED) ? seed : state_q;

    for (genvar i = 0; i < W; i++) begin : g_tap
        assign tap_prod[i] = cur[i] & mask[i];
    end

    assign key = ^tap_prod;

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_IDLE, ACT_HOLD:           state_d = state_q;
            ACT_LOAD:                     state_d = seed;
            ACT_STEP_FRAME, ACT_STEP_SEED: state_d = {cur[W-2:0], key};
            ACT_STEP_SELF:                state_d = {state_q[W-2:0], data_in ^ key};
            default:                      state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_SEED;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/lfsr_scr_ctrl.sv
module lfsr_scr_ctrl
    import lfsr_scr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_vld,
    input  logic     bit_in,
    input  logic     frame_start,
    input  logic     self_mode,
    input  logic     en_sel_sw,
    input  logic     sw_en,
    input  logic     hw_en,
    input  logic     key,
    output scr_act_e act,
    output logic     bit_out,
    output logic     out_vld
);

    scr_state_e state_q, state_d;
    logic       eff_en;
    logic       in_q;
    logic       key_q;
    logic       vld_q;

    assign eff_en = en_sel_sw ? sw_en : hw_en;

    // Register action for this clock
    always_comb begin
        if (!bit_vld)
            act = ACT_IDLE;
        else if (eff_en)
            act = self_mode ? ACT_STEP_SELF
                            : (frame_start ? ACT_STEP_SEED : ACT_STEP_FRAME);
        else
            act = (!self_mode && frame_start) ? ACT_LOAD : ACT_HOLD;
    end

    // Next state: SCR_BIT, PASS_BIT, IDLE_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (bit_vld) state_d = eff_en ? ST_SCR : ST_PASS;
            ST_SCR:  if (bit_vld) state_d = eff_en ? ST_SCR : ST_PASS;
            default: state_d = ST_PASS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // Output stage capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= 1'b0;
            key_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= bit_vld;
            if (bit_vld) begin
                in_q  <= bit_in;
                key_q <= key;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_PASS: bit_out = in_q;
            ST_SCR:  bit_out = in_q ^ key_q;
            default: bit_out = in_q;
        endcase
        out_vld = vld_q;
    end

endmodule

// File: rtl/lfsr_scrambler.sv
module lfsr_scrambler
    import lfsr_scr_pkg::*;
#(
    parameter int unsigned W          = 24,
    parameter int unsigned RST_TAP_HI = 15,
    parameter int unsigned RST_TAP_LO = 14,
    parameter int unsigned RST_ONES   = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_mask,
    input  logic [W-1:0] cfg_seed,
    input  logic         self_mode,
    input  logic         en_sel_sw,
    input  logic         sw_en,
    input  logic         hw_en,
    input  logic         frame_start,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic         bit_out,
    output logic         out_vld
);

    localparam logic [W-1:0] ONE_W    = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] RST_MASK = (ONE_W << (RST_TAP_HI - 1)) |
                                        (ONE_W << (RST_TAP_LO - 1));
    localparam logic [W-1:0] RST_SEED = (ONE_W << RST_ONES) - ONE_W;

    logic [W-1:0] mask_q;
    logic [W-1:0] seed_q;
    logic [W-1:0] lfsr_state;
    logic         key;
    scr_act_e     act;

    lfsr_scr_cfg #(.W(W), .RST_MASK(RST_MASK), .RST_SEED(RST_SEED)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_mask (cfg_mask),
        .cfg_seed (cfg_seed),
        .mask_q   (mask_q),
        .seed_q   (seed_q)
    );

    lfsr_scr_core #(.W(W), .RST_SEED(RST_SEED)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .mask    (mask_q),
        .seed    (seed_q),
        .data_in (bit_in),
        .key     (key),
        .state_q (lfsr_state)
    );

    lfsr_scr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .frame_start (frame_start),
        .self_mode   (self_mode),
        .en_sel_sw   (en_sel_sw),
        .sw_en       (sw_en),
        .hw_en       (hw_en),
        .key         (key),
        .act         (act),
        .bit_out     (bit_out),
        .out_vld     (out_vld)
    );

endmodule

// File: rtl/lfsr_scrambler_chk.sv
module lfsr_scrambler_chk #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_wr,
    input logic [W-1:0] cfg_mask,
    input logic [W-1:0] cfg_seed,
    input logic         self_mode,
    input logic         en_sel_sw,
    input logic         sw_en,
    input logic         hw_en,
    input logic         frame_start,
    input logic         bit_vld,
    input logic         bit_in,
    input logic         bit_out,
    input logic         out_vld,
    input logic [W-1:0] lfsr_state,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] seed_q
);

    logic eff;
    assign eff = en_sel_sw ? sw_en : hw_en;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> out_vld);

    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !out_vld);

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !eff) |=> (bit_out == $past(bit_in)));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !eff && (self_mode || !frame_start)) |=> $stable(lfsr_state));

    // R5
    disabled_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !eff && !self_mode && frame_start) |=> (lfsr_state == $past(seed_q)));

    // R3
    frame_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && eff && !self_mode) |=> (lfsr_state[0] == (bit_out ^ $past(bit_in))));

    // R4
    self_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && eff && self_mode) |=> (lfsr_state[0] == bit_out));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(lfsr_state) && $stable(bit_out)));

    // R7
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((mask_q == $past(cfg_mask)) && (seed_q == $past(cfg_seed))));

endmodule

bind lfsr_scrambler lfsr_scrambler_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_mask    (cfg_mask),
    .cfg_seed    (cfg_seed),
    .self_mode   (self_mode),
    .en_sel_sw   (en_sel_sw),
    .sw_en       (sw_en),
    .hw_en       (hw_en),
    .frame_start (frame_start),
    .bit_vld     (bit_vld),
    .bit_in      (bit_in),
    .bit_out     (bit_out),
    .out_vld     (out_vld),
    .lfsr_state  (lfsr_state),
    .mask_q      (mask_q),
    .seed_q      (seed_q)
);

// File: tb/lfsr_scrambler_bench.sv
module lfsr_scrambler_bench;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_mask = '0;
    logic [W-1:0] cfg_seed = '0;
    logic         self_mode = 1'b0;
    logic         en_sel_sw = 1'b0;
    logic         sw_en = 1'b0;
    logic         hw_en = 1'b0;
    logic         frame_start = 1'b0;
    logic         bit_vld = 1'b0;
    logic         bit_in = 1'b0;
    logic         bit_out;
    logic         out_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [W-1:0] m_mask, m_seed, m_state;
    logic         e_out, e_vld;

    always #2 clk = ~clk;

    lfsr_scrambler u_lfsr_scrambler (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
        .cfg_seed(cfg_seed), .self_mode(self_mode), .en_sel_sw(en_sel_sw),
        .sw_en(sw_en), .hw_en(hw_en), .frame_start(frame_start),
        .bit_vld(bit_vld), .bit_in(bit_in), .bit_out(bit_out), .out_vld(out_vld)
    );

    function automatic logic parity(input logic [W-1:0] v, input logic [W-1:0] m);
        logic p = 1'b0;
        for (int i = 0; i < W; i++) p = p ^ (v[i] & m[i]);
        return p;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One clock: inputs already driven, model advances at the edge, compare after
    task automatic step(input logic vld, input logic fs, input logic din, input string tag);
        logic en, k, o;
        logic [W-1:0] cur;
        bit_vld = vld; frame_start = fs; bit_in = din;
        @(posedge clk);
        en = en_sel_sw ? sw_en : hw_en;
        if (vld) begin
            if (en && self_mode) begin
                k = parity(m_state, m_mask);
                o = din ^ k;
                m_state = {m_state[W-2:0], o};
            end else if (en) begin
                cur = fs ? m_seed : m_state;
                k = parity(cur, m_mask);
                o = din ^ k;
                m_state = {cur[W-2:0], k};
            end else begin
                o = din;
                if (!self_mode && fs) m_state = m_seed;
            end
            e_out = o;
        end
        e_vld = vld;
        if (cfg_wr) begin
            m_mask = cfg_mask;
            m_seed = cfg_seed;
        end
        @(negedge clk);
        check(tag, out_vld, e_vld, "out_vld");
        check(tag, bit_out, e_out, "bit_out");
    endtask

    task automatic cfg_write(input logic [W-1:0] mk, input logic [W-1:0] sd);
        cfg_wr = 1'b1; cfg_mask = mk; cfg_seed = sd;
        step(1'b0, 1'b0, 1'b0, "R7");
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d_state;
        logic din, rec;
        m_mask = 24'h006000; m_seed = 24'h007FFF; m_state = 24'h007FFF;
        e_out = 1'b0; e_vld = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset outputs
        check("R1", out_vld, 1'b0, "out_vld after reset");
        check("R1", bit_out, 1'b0, "bit_out after reset");

        // R1 default polynomial and seed, frame mode, hardware enable
        hw_en = 1'b1;
        step(1'b1, 1'b1, 1'b0, "R1");
        for (int i = 0; i < 39; i++) step(1'b1, 1'b0, 1'b0, "R1");

        // R5 preamble passes with enable low; frame start loads seed
        hw_en = 1'b0;
        step(1'b1, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, logic'(i % 3 == 0), "R5");
        hw_en = 1'b1;
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, logic'($urandom_range(1)), "R3");

        // R8 gaps in the valid strobe
        for (int i = 0; i < 16; i++) step(logic'(i % 2), 1'b0, logic'($urandom_range(1)), "R8");

        // R6 software select ignores hw_en
        en_sel_sw = 1'b1; sw_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            hw_en = logic'(i % 2);
            step(1'b1, 1'b0, logic'($urandom_range(1)), "R6");
        end
        sw_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            hw_en = logic'(i % 2);
            step(1'b1, 1'b0, logic'($urandom_range(1)), "R6");
        end
        en_sel_sw = 1'b0; sw_en = 1'b0; hw_en = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, "R6");

        // R7 new polynomial x^23 + x^18 + 1 and seed, written at run time
        cfg_write(24'h420000, 24'hA5C3E1);
        step(1'b1, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 47; i++) step(1'b1, 1'b0, logic'($urandom_range(1)), "R7");
        // R7 a bit accepted with the write still uses old values
        cfg_wr = 1'b1; cfg_mask = 24'h006000; cfg_seed = 24'h00ABCD;
        step(1'b1, 1'b1, 1'b1, "R7");
        cfg_wr = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, "R7");
        cfg_write(24'h420000, 24'h123456);

        // R4/R9 self-synchronizing mode with stray frame-start flags
        self_mode = 1'b1; en_sel_sw = 1'b1; sw_en = 1'b1;
        d_state = '0;
        for (int i = 0; i < 120; i++) begin
            din = logic'($urandom_range(1));
            step(1'b1, logic'(i % 17 == 5), din, "R4");
            rec = bit_out ^ parity(d_state, 24'h420000);
            d_state = {d_state[W-2:0], bit_out};
            if (i >= 24) check("R9", rec, din, "descrambled bit");
        end
        // R5 disabled in self mode: hold, frame start ignored
        sw_en = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b1, logic'(i == 2), logic'(i % 2), "R5");
        sw_en = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, logic'($urandom_range(1)), "R4");

        // R3 frame mode continuing without frame start
        self_mode = 1'b0;
        for (int i = 0; i < 24; i++) step(1'b1, 1'b0, logic'($urandom_range(1)), "R3");
        step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b0, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule